// File: doc/BRIEF.md
# Rheostat Command Decoder and Control Register

This block sits behind the serial front end of a digital rheostat. Every complete 16-bit word that the front end delivers is decoded into an operation on a wiper code register, a small control register or a shutdown flag. The block also computes the response word that the front end shifts out during the following frame. Bits 15:14 of a word are unused. Bits 13:10 hold the command, and bits 9:0 hold the data.

The wiper is locked after reset. Software must set the wiper-unlock control bit before a write-wiper command has any effect. The restore command always reloads the wiper from the value that the nonvolatile store controller presents. Store commands are forwarded to that controller as a one-cycle request, and only when the program-enable control bit is set. While the controller reports busy, every word is discarded. A parameter selects the 8-bit resolution variant. In that variant the two low wiper bits are forced to zero on writes and on reads.

Top module: `rheo_cmd_top`

## Requirements
- R1: After reset, wiper_o is 0x200 (mid-scale), shutdown_o, cal_dis_o and store_req_o are 0, all control bits are 0, and rsp_o is 0.
- R2: An accepted command 1 with control bit C1 (wiper unlock, control bit 1) set loads data bits 9:0 into wiper_o at the clock edge that samples the word.
- R3: An accepted command 1 while C1 is 0 leaves wiper_o unchanged.
- R4: Command 7 loads data bits 2:0 into control bits C2..C0 (C0 = program enable, C1 = wiper unlock, C2 = calibration disable, which drives cal_dis_o). Data bit 3 has no effect.
- R5: Command 8 sets rsp_o to {12'b0, store_ok_i, C2, C1, C0}.
- R6: Command 2 sets rsp_o to the current wiper code, zero-extended.
- R7: Command 5 drives mem_addr_o with word bits 5:0 and sets rsp_o to mem_data_i, zero-extended.
- R8: Command 6 sets rsp_o to last_addr_i, zero-extended.
- R9: Every other accepted command (0, 1, 3, 4, 7, 9, 10 to 15) sets rsp_o to 0. rsp_o holds its value when no word is accepted.
- R10: Command 3 raises store_req_o for exactly one cycle when C0 is 1. With C0 at 0 the command is dropped.
- R11: Command 4 loads restore_code_i into wiper_o regardless of C1 and clears shutdown_o.
- R12: Command 9 sets shutdown_o to data bit 0. All commands are still executed while shutdown_o is 1.
- R13: While store_busy_i is 1, a presented word changes nothing: wiper, control bits, shutdown, response and store_req_o stay as they were.
- R14: With LOW_RES=1, wiper loads and the values returned by commands 2 and 5 have bits 1:0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_valid_i | input | 1 | One-cycle strobe marking a complete word |
| word_i | input | 16 | Received word |
| store_busy_i | input | 1 | Nonvolatile store controller is busy |
| store_ok_i | input | 1 | Last program operation succeeded (read-only C3) |
| restore_code_i | input | 10 | Wiper value to load on restore |
| mem_data_i | input | 10 | Memory content at mem_addr_o |
| last_addr_i | input | 6 | Address of the last programmed location |
| mem_addr_o | output | 6 | Memory location selected by the word |
| wiper_o | output | 10 | Wiper code |
| shutdown_o | output | 1 | Shutdown flag |
| cal_dis_o | output | 1 | Calibration disable (C2) |
| store_req_o | output | 1 | One-cycle store request |
| rsp_o | output | 16 | Response word for the next frame |

## Verification
A corrupted wiper or lock bit shows up on wiper_o at the edge that samples the offending word. A wrong control bit stays hidden until a later write, store or control read exposes it through wiper_o, store_req_o or rsp_o. Response faults show up only on the cycle after a read, so each read is paired with a read of a different kind. The same tracking runs through busy windows and shutdown, because those are where a dropped or leaked update would be silent.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_WR_WIPER = 4'd1,
    CMD_RD_WIPER = 4'd2,
    CMD_STORE    = 4'd3,
    CMD_RESTORE  = 4'd4,
    CMD_RD_MEM   = 4'd5,
    CMD_RD_LAST  = 4'd6,
    CMD_WR_CTRL  = 4'd7,
    CMD_RD_CTRL  = 4'd8,
    CMD_SHDN     = 4'd9
  } cmd_e;

  typedef struct packed {
    logic wr_wiper;
    logic store;
    logic restore;
    logic wr_ctrl;
    logic shdn;
    logic rd_wiper;
    logic rd_mem;
    logic rd_last;
    logic rd_ctrl;
  } op_t;
endpackage

// File: rtl/rheo_cmd_dec.sv
module rheo_cmd_dec
  import rheo_pkg::*;
#(
  parameter int DATA_W = 10,
  localparam int WORD_W = DATA_W + CMD_W + 2
) (
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              store_busy_i,
  output logic              accept_o,
  output op_t               op_o,
  output logic [DATA_W-1:0] data_o
);
  cmd_e cmd;

  assign cmd      = cmd_e'(word_i[DATA_W +: CMD_W]);
  assign data_o   = word_i[DATA_W-1:0];
  assign accept_o = word_valid_i && !store_busy_i; // busy drops the whole word

  always_comb begin
    op_o = '0;
    if (accept_o) begin
      unique case (cmd)
        CMD_WR_WIPER: op_o.wr_wiper = 1'b1;
        CMD_RD_WIPER: op_o.rd_wiper = 1'b1;
        CMD_STORE:    op_o.store    = 1'b1;
        CMD_RESTORE:  op_o.restore  = 1'b1;
        CMD_RD_MEM:   op_o.rd_mem   = 1'b1;
        CMD_RD_LAST:  op_o.rd_last  = 1'b1;
        CMD_WR_CTRL:  op_o.wr_ctrl  = 1'b1;
        CMD_RD_CTRL:  op_o.rd_ctrl  = 1'b1;
        CMD_SHDN:     op_o.shdn     = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/rheo_ctrl_regs.sv
module rheo_ctrl_regs
  import rheo_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter bit LOW_RES = 1'b0,
  localparam int CTRL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_t               op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] restore_code_i,
  output logic [DATA_W-1:0] wiper_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              shutdown_o,
  output logic              store_req_o
);
  localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] MASK = LOW_RES ? {{(DATA_W-2){1'b1}}, 2'b00}
                                               : {DATA_W{1'b1}};

  logic [DATA_W-1:0] wiper_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              shdn_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wiper_q <= MID;
      ctrl_q  <= '0;
      shdn_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (op_i.restore)                    wiper_q <= restore_code_i & MASK;
      else if (op_i.wr_wiper && ctrl_q[1]) wiper_q <= data_i & MASK;
      if (op_i.wr_ctrl) ctrl_q <= data_i[CTRL_W-1:0];
      if (op_i.restore)   shdn_q <= 1'b0;
      else if (op_i.shdn) shdn_q <= data_i[0];
      req_q <= op_i.store && ctrl_q[0];
    end
  end

  assign wiper_o     = wiper_q;
  assign ctrl_o      = ctrl_q;
  assign shutdown_o  = shdn_q;
  assign store_req_o = req_q;

  assert_locked_wiper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i.wr_wiper && !ctrl_q[1]) |=> $stable(wiper_q));
  assert_store_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(ctrl_q[0] && op_i.store));
  assert_store_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q || $past(op_i.store));
  assert_shdn_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_q) |-> $past(op_i.restore || op_i.shdn));
  assert_shdn_entry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_q) |-> $past(op_i.shdn && data_i[0]));
endmodule

// File: rtl/rheo_rsp_reg.sv
module rheo_rsp_reg
  import rheo_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int ADDR_W  = 6,
  parameter bit LOW_RES = 1'b0,
  localparam int WORD_W = DATA_W + CMD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  op_t               op_i,
  input  logic [DATA_W-1:0] wiper_i,
  input  logic [2:0]        ctrl_i,
  input  logic              store_ok_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic [WORD_W-1:0] rsp_o
);
  localparam logic [DATA_W-1:0] MASK = LOW_RES ? {{(DATA_W-2){1'b1}}, 2'b00}
                                               : {DATA_W{1'b1}};

  logic [WORD_W-1:0] rsp_q, rsp_d;

  always_comb begin
    rsp_d = '0;
    if (op_i.rd_wiper)     rsp_d = WORD_W'(wiper_i);
    else if (op_i.rd_mem)  rsp_d = WORD_W'(mem_data_i & MASK);
    else if (op_i.rd_last) rsp_d = WORD_W'(last_addr_i);
    else if (op_i.rd_ctrl) rsp_d = WORD_W'({store_ok_i, ctrl_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rsp_q <= '0;
    else if (accept_i) rsp_q <= rsp_d;
  end

  assign rsp_o = rsp_q;

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(rsp_q));
  assert_rd_wiper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.rd_wiper |=> rsp_q == WORD_W'($past(wiper_i)));
endmodule

// File: rtl/rheo_cmd_top.sv
module rheo_cmd_top
  import rheo_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int ADDR_W  = 6,
  parameter bit LOW_RES = 1'b0,
  localparam int WORD_W = DATA_W + CMD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              store_busy_i,
  input  logic              store_ok_i,
  input  logic [DATA_W-1:0] restore_code_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] wiper_o,
  output logic              shutdown_o,
  output logic              cal_dis_o,
  output logic              store_req_o,
  output logic [WORD_W-1:0] rsp_o
);
  logic              accept;
  op_t               op;
  logic [DATA_W-1:0] data;
  logic [2:0]        ctrl;

  assign mem_addr_o = word_i[ADDR_W-1:0];
  assign cal_dis_o  = ctrl[2];

  rheo_cmd_dec #(.DATA_W(DATA_W)) u_dec (
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .store_busy_i (store_busy_i),
    .accept_o     (accept),
    .op_o         (op),
    .data_o       (data)
  );

  rheo_ctrl_regs #(.DATA_W(DATA_W), .LOW_RES(LOW_RES)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_i           (op),
    .data_i         (data),
    .restore_code_i (restore_code_i),
    .wiper_o        (wiper_o),
    .ctrl_o         (ctrl),
    .shutdown_o     (shutdown_o),
    .store_req_o    (store_req_o)
  );

  rheo_rsp_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOW_RES(LOW_RES)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .op_i        (op),
    .wiper_i     (wiper_o),
    .ctrl_i      (ctrl),
    .store_ok_i  (store_ok_i),
    .mem_data_i  (mem_data_i),
    .last_addr_i (last_addr_i),
    .rsp_o       (rsp_o)
  );

  assert_busy_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_busy_i |=> $stable(wiper_o) && $stable(ctrl) && $stable(shutdown_o)
                     && $stable(rsp_o) && !store_req_o);
  assert_ctrl_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !store_busy_i && word_i[DATA_W +: CMD_W] == 4'd7)
      |=> ctrl == $past(word_i[2:0]));
endmodule

// File: tb/rheo_cmd_top_test.sv
`timescale 1ns/1ps
module rheo_cmd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] word = '0;
  logic        busy = 1'b0;
  logic        ok = 1'b0;
  logic [9:0]  rcode = 10'h0;
  logic [9:0]  mdata, mdata_lr;
  logic [5:0]  last = 6'h0;
  logic [5:0]  maddr, maddr_lr;
  logic [9:0]  wiper, wiper_lr;
  logic        sd, sd_lr, cal, cal_lr, req, req_lr;
  logic [15:0] rsp, rsp_lr;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  // model state
  int m_wiper, m_ctrl, m_sd, m_req, m_rsp, m_rsp_lr;

  always #2 clk = ~clk;

  function automatic logic [9:0] mem_fn(logic [5:0] a);
    return 10'((int'(a) * 37 + 5) & 'h3FF);
  endfunction
  assign mdata    = mem_fn(maddr);
  assign mdata_lr = mem_fn(maddr_lr);

  rheo_cmd_top uut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_i(word),
    .store_busy_i(busy), .store_ok_i(ok), .restore_code_i(rcode),
    .mem_data_i(mdata), .last_addr_i(last), .mem_addr_o(maddr),
    .wiper_o(wiper), .shutdown_o(sd), .cal_dis_o(cal),
    .store_req_o(req), .rsp_o(rsp)
  );

  rheo_cmd_top #(.LOW_RES(1'b1)) uut_lr (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_i(word),
    .store_busy_i(busy), .store_ok_i(ok), .restore_code_i(rcode),
    .mem_data_i(mdata_lr), .last_addr_i(last), .mem_addr_o(maddr_lr),
    .wiper_o(wiper_lr), .shutdown_o(sd_lr), .cal_dis_o(cal_lr),
    .store_req_o(req_lr), .rsp_o(rsp_lr)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wiper = 'h200; m_ctrl = 0; m_sd = 0; m_req = 0; m_rsp = 0; m_rsp_lr = 0;
    end else begin
      m_req = 0;
      if (valid && !busy) begin
        int c, d;
        c = int'(word[13:10]);
        d = int'(word[9:0]);
        m_rsp = 0; m_rsp_lr = 0;
        case (c)
          1: if ((m_ctrl & 2) != 0) m_wiper = d;
          2: begin m_rsp = m_wiper; m_rsp_lr = m_wiper & 'h3FC; end
          3: m_req = m_ctrl & 1;
          4: begin m_wiper = int'(rcode); m_sd = 0; end
          5: begin m_rsp = int'(mem_fn(word[5:0])); m_rsp_lr = m_rsp & 'h3FC; end
          6: begin m_rsp = int'(last); m_rsp_lr = m_rsp; end
          7: m_ctrl = d & 7;
          8: begin m_rsp = (int'(ok) << 3) | m_ctrl; m_rsp_lr = m_rsp; end
          9: m_sd = d & 1;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of both instances against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk("R2/R3/R11 wiper",     int'(wiper), m_wiper);
      chk("R14 wiper lowres",    int'(wiper_lr), m_wiper & 'h3FC);
      chk("R12 shutdown",        int'(sd), m_sd);
      chk("R4 cal_dis",          int'(cal), (m_ctrl >> 2) & 1);
      chk("R10 store_req",       int'(req), m_req);
      chk("R5/R6/R7/R8/R9 rsp",  int'(rsp), m_rsp);
      chk("R14 rsp lowres",      int'(rsp_lr), m_rsp_lr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [15:0] mk(int c, int d);
    return {2'b00, 4'(c), 10'(d)};
  endfunction

  task automatic send(int c, int d);
    word  = mk(c, d);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    word  = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 wiper", int'(wiper), 'h200);
    chk("R1 shutdown", int'(sd), 0);
    chk("R1 cal_dis", int'(cal), 0);
    chk("R1 store_req", int'(req), 0);
    chk("R1 rsp", int'(rsp), 0);
    model_on = 1'b1;

    send(1, 'h155);                         // locked
    chk("R3 locked write", int'(wiper), 'h200);
    send(7, 'hA);                           // bit3 ignored, C1=1
    send(8, 0);
    chk("R4/R5 ctrl read", int'(rsp), 'h2);
    send(1, 'h155);
    chk("R2 write", int'(wiper), 'h155);
    chk("R14 write lowres", int'(wiper_lr), 'h154);
    send(2, 0);
    chk("R6 read wiper", int'(rsp), 'h155);
    chk("R14 read lowres", int'(rsp_lr), 'h154);
    send(3, 0);
    chk("R10 store dropped", int'(req), 0);
    send(7, 'h7);
    chk("R4 cal_dis set", int'(cal), 1);
    send(3, 0);
    chk("R10 store req", int'(req), 1);
    @(negedge clk);
    chk("R10 one cycle", int'(req), 0);
    ok = 1'b1;
    send(8, 0);
    chk("R5 ok flag", int'(rsp), 'hF);

    busy = 1'b1;
    send(1, 'h0AA);
    send(3, 0);
    chk("R13 busy wiper", int'(wiper), 'h155);
    chk("R13 busy rsp", int'(rsp), 'hF);
    chk("R13 busy req", int'(req), 0);
    busy = 1'b0;

    send(5, 'h2A);
    chk("R7 read mem", int'(rsp), int'(mem_fn(6'h2A)));
    chk("R14 mem lowres", int'(rsp_lr), int'(mem_fn(6'h2A)) & 'h3FC);
    last = 6'h31;
    send(6, 0);
    chk("R8 last addr", int'(rsp), 'h31);
    send(0, 'h3FF);
    chk("R9 nop clears", int'(rsp), 0);

    send(9, 1);
    chk("R12 shutdown on", int'(sd), 1);
    send(1, 'h3FF);
    chk("R12 write in shutdown", int'(wiper), 'h3FF);
    send(9, 'h2);
    chk("R12 shutdown off", int'(sd), 0);
    send(9, 1);
    rcode = 10'h1E7;
    send(4, 0);
    chk("R11 restore", int'(wiper), 'h1E7);
    chk("R11 restore exits shutdown", int'(sd), 0);
    send(7, 0);
    rcode = 10'h0C3;
    send(4, 0);
    chk("R11 restore while locked", int'(wiper), 'h0C3);
    send(2, 0);
    send(12, 0);
    chk("R9 unused code", int'(rsp), 0);
    repeat (3) @(negedge clk);

    model_on = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule